// File: doc/BRIEF.md
# Protected Watchdog Timer

The block is a watchdog timer behind an 8-bit register bus. It is built so that software that has lost control is unlikely to keep it quiet by accident. It has two registers. A mode register chooses the timeout period, the tick source, and whether the watchdog runs at all. After each reset this register takes exactly one byte-wide write. A restart register takes a single magic byte. That byte zeroes the counter and counting starts again.

The block raises a one-cycle internal reset request in two cases: when the counter runs past the chosen period, or when software touches the registers in a forbidden way. The forbidden ways are a repeated mode write, a bad pattern in the mode tag bits, a wrong restart byte, and a bit-manipulation access to the restart register. The surrounding system routes the request to its reset logic. Clock generation and the processor are outside the block. The two tick inputs are qualified enables from that clock logic.

Top module: `wdt_guard`

## Requirements
- R1: After reset the mode register (byte address 0xFF48) takes one byte-wide write. A later byte-wide write to it, while the watchdog runs, raises the reset request and leaves the register unchanged.
- R2: If the accepted mode write sets bit 4 to 1, the counter stops. After that, further mode writes have no effect and raise no request.
- R3: A single-bit (bus_bit=1) write to the mode register is ignored. It raises no request, changes no bit, and does not use up the one allowed write.
- R4: A first mode write whose bits 7..5 are not 0,1,1 raises the request. The register keeps its value and stays unwritten.
- R5: A byte-wide write of 0xAC to the restart register (byte address 0xFF49) sets the counter to zero, and this wins over an overflow in the same cycle. An accepted mode write also zeroes the counter.
- R6: A byte-wide write of any other value to the restart register raises the request.
- R7: A single-bit access to the restart register, read or write, raises the request.
- R8: A read returns 0x9A from the restart register, the current mode byte from the mode register (0x67 after reset), and 0x00 from any other address or when bus_re is low. The read data is combinational.
- R9: Mode bits 2..0 (n) set the period to 2^(11+n) ticks. The tick that would take the counter past 2^(11+n)-1 raises the request and wraps the counter to zero.
- R10: Mode bit 3 picks the tick: 0 counts tick_lo and ignores tick_hi, 1 counts tick_hi and ignores tick_lo.
- R11: rst_req is registered. It is high for exactly the one cycle after the clock edge that sampled the cause. Asserting rst_n restores mode 0x67, unwritten, counter at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_lo | input | 1 | Count enable from the first tick source |
| tick_hi | input | 1 | Count enable from the second tick source |
| bus_addr | input | 16 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_bit | input | 1 | Access is a single-bit manipulation |
| bus_rdata | output | 8 | Read data |
| rst_req | output | 1 | One-cycle internal reset request |

## Verification
The counter is driven up to exactly one tick short of the period, restarted, and then run one tick past the period. This shows the restart code from an off-by-one in the limit compare. The same run is repeated with period select 1 on the second tick source, while the unselected source toggles. That pass tells the tick multiplexer apart from a fixed source, and the per-select limit from the base limit.

Each illegal access is applied from a clean reset, and the bench compares the cycle in which the request appears against a behavioural model. The stopped configuration and the single-bit mode write are then followed by byte writes and read-backs. These show whether the lock is taken and whether a write is counted as used.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;
  localparam int unsigned DATA_W     = 8;
  localparam int unsigned SEL_W      = 3;
  localparam logic [2:0]  MODE_TAG   = 3'b011;
  localparam logic [7:0]  MODE_RESET = 8'h67;
  localparam logic [7:0]  KICK_CODE  = 8'hAC;
  localparam logic [7:0]  KICK_READ  = 8'h9A;

  typedef struct packed {
    logic [2:0]       tag;
    logic             halt;
    logic             src_hi;
    logic [SEL_W-1:0] sel;
  } mode_t;
endpackage

// File: rtl/wdt_regif.sv
module wdt_regif
  import wdt_guard_pkg::*;
#(
  parameter int unsigned      ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 16'hFF48,
  parameter logic [ADDR_W-1:0] KICK_ADDR = 16'hFF49
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic              bus_bit,
  output mode_t             mode_q,
  output logic              written_q,
  output logic              clr_o,
  output logic              viol_o
);
  logic  hit_mode, hit_kick, mode_wr, mode_ld;
  mode_t mode_d;

  assign hit_mode = (bus_addr == MODE_ADDR);
  assign hit_kick = (bus_addr == KICK_ADDR);
  assign mode_wr  = bus_we & hit_mode & ~bus_bit;

  always_comb begin
    mode_d  = mode_t'(bus_wdata);
    mode_ld = 1'b0;
    clr_o   = 1'b0;
    viol_o  = 1'b0;
    if (mode_wr) begin
      if (written_q) begin
        if (!mode_q.halt) viol_o = 1'b1;
      end else if (bus_wdata[7:5] != MODE_TAG) begin
        viol_o = 1'b1;
      end else begin
        mode_ld = 1'b1;
        clr_o   = 1'b1;
      end
    end
    if (hit_kick && bus_bit && (bus_we || bus_re)) begin
      viol_o = 1'b1;
    end else if (hit_kick && bus_we) begin
      if (bus_wdata == KICK_CODE) clr_o  = 1'b1;
      else                        viol_o = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= mode_t'(MODE_RESET);
      written_q <= 1'b0;
    end else if (mode_ld) begin
      mode_q    <= mode_d;
      written_q <= 1'b1;
    end
  end

  p_stopped_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (written_q && mode_q.halt) |=> ($stable(mode_q) && written_q));
  p_bad_tag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && !written_q && bus_wdata[7:5] != MODE_TAG) |=> !written_q);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned SEL_W     = 3,
  parameter int unsigned BASE_LOG2 = 11,
  localparam int unsigned NSEL     = 1 << SEL_W,
  localparam int unsigned CNT_W    = BASE_LOG2 + NSEL - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             src_hi,
  input  logic [SEL_W-1:0] sel,
  input  logic             tick_lo,
  input  logic             tick_hi,
  input  logic             clr,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [NSEL-1:0]  at_lim;
  logic             tick, step_en, wrap, cnt_en;

  for (genvar i = 0; i < NSEL; i++) begin : g_lim
    localparam logic [CNT_W:0] LIM = (CNT_W+1)'(1) << (BASE_LOG2 + i);
    assign at_lim[i] = (cnt_q == CNT_W'(LIM - 1'b1));
  end

  assign tick    = src_hi ? tick_hi : tick_lo;
  assign step_en = run & tick;
  assign wrap    = at_lim[sel];
  assign cnt_en  = clr | step_en;
  assign ovf_o   = step_en & wrap & ~clr;

  always_comb begin
    if (clr || wrap) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  p_clr_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
  p_stop_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(cnt_q));
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_guard_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned BASE_LOG2 = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_lo,
  input  logic              tick_hi,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic              bus_bit,
  output logic [7:0]        bus_rdata,
  output logic              rst_req
);
  localparam logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(16'hFF48);
  localparam logic [ADDR_W-1:0] KICK_ADDR = ADDR_W'(16'hFF49);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  mode_t      mode_q;
  logic       written_q, clr, viol, ovf, req_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  wdt_regif #(.ADDR_W(ADDR_W), .MODE_ADDR(MODE_ADDR), .KICK_ADDR(KICK_ADDR)) u_regif (
    .clk(clk), .rst_n(rst_int_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_bit(bus_bit),
    .mode_q(mode_q), .written_q(written_q), .clr_o(clr), .viol_o(viol)
  );

  wdt_counter #(.SEL_W(SEL_W), .BASE_LOG2(BASE_LOG2)) u_counter (
    .clk(clk), .rst_n(rst_int_n), .run(~mode_q.halt), .src_hi(mode_q.src_hi),
    .sel(mode_q.sel), .tick_lo(tick_lo), .tick_hi(tick_hi), .clr(clr), .ovf_o(ovf)
  );

  assign req_d = viol | ovf;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) rst_req <= 1'b0;
    else            rst_req <= req_d;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_re) begin
      if (bus_addr == KICK_ADDR)      bus_rdata = KICK_READ;
      else if (bus_addr == MODE_ADDR) bus_rdata = mode_q;
    end
  end

  p_second_write_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_we && !bus_bit && bus_addr == MODE_ADDR && written_q && !mode_q.halt) |=> rst_req);
  p_wrong_code_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_we && !bus_bit && bus_addr == KICK_ADDR && bus_wdata != KICK_CODE) |=> rst_req);
  p_bit_kick_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((bus_we || bus_re) && bus_bit && bus_addr == KICK_ADDR) |=> rst_req);
  p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!bus_we && !bus_re && !tick_lo && !tick_hi) |=> !rst_req);
endmodule

// File: tb/tb_wdt_guard.sv
module tb_wdt_guard;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] A_MODE = 16'hFF48;
  localparam logic [15:0] A_KICK = 16'hFF49;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_lo = 1'b0, tick_hi = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic bus_we = 1'b0, bus_re = 1'b0, bus_bit = 1'b0;
  logic [7:0] bus_rdata;
  logic rst_req;

  int n_tests = 0, n_fail = 0, req_seen = 0, cyc = 0;
  int m_mode, m_cnt, m_exp_req;
  bit m_written;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_guard dut (.clk(clk), .rst_n(rst_n), .tick_lo(tick_lo), .tick_hi(tick_hi),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
    .bus_bit(bus_bit), .bus_rdata(bus_rdata), .rst_req(rst_req));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run hung (act %0d cycles, exp < 150000)", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic check(input int act, input int exp, input string tag);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: act 0x%0h exp 0x%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int model_read(input bit re, input logic [15:0] a);
    if (!re) return 0;
    if (a == A_KICK) return 'h9A;
    if (a == A_MODE) return m_mode;
    return 0;
  endfunction

  task automatic model_step(input bit we, re, bt, input logic [15:0] a,
                            input int d, input bit tl, th);
    bit clr = 0; int lim;
    m_exp_req = 0;
    if (we && a == A_MODE && !bt) begin
      if (m_written) begin
        if (((m_mode >> 4) & 1) == 0) m_exp_req = 1;
      end else if (((d >> 5) & 7) != 3) m_exp_req = 1;
      else begin m_mode = d; m_written = 1; clr = 1; end
    end
    if (a == A_KICK && bt && (we || re)) m_exp_req = 1;
    else if (a == A_KICK && we) begin
      if (d == 'hAC) clr = 1; else m_exp_req = 1;
    end
    lim = 1 << (11 + (m_mode & 7));
    if (clr) m_cnt = 0;
    else if (((m_mode >> 4) & 1) == 0 && ((((m_mode >> 3) & 1) == 1) ? th : tl)) begin
      if (m_cnt == lim - 1) begin m_cnt = 0; m_exp_req = 1; end
      else m_cnt++;
    end
  endtask

  task automatic step(input bit we, re, bt, input logic [15:0] a, input int d,
                      input bit tl, th, input string tag);
    bus_we = we; bus_re = re; bus_bit = bt; bus_addr = a; bus_wdata = d[7:0];
    tick_lo = tl; tick_hi = th;
    #1;
    check(bus_rdata, model_read(re, a), {tag, " read data"});
    @(posedge clk);
    model_step(we, re, bt, a, d, tl, th);
    @(negedge clk);
    if (rst_req) req_seen++;
    check(rst_req, m_exp_req, {tag, " reset request"});
  endtask

  task automatic idle(input int n, input bit tl, th, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 16'h0, 0, tl, th, tag);
  endtask
  task automatic wr(input logic [15:0] a, input int d, input string tag);
    step(1, 0, 0, a, d, 0, 0, tag);
  endtask
  task automatic rd(input logic [15:0] a, input string tag);
    step(0, 1, 0, a, 0, 0, 0, tag);
  endtask

  task automatic do_reset();
    bus_we = 0; bus_re = 0; bus_bit = 0; tick_lo = 0; tick_hi = 0;
    rst_n = 0;
    m_mode = 'h67; m_written = 0; m_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(4, 0, 0, "R11");
  endtask

  initial begin
    int base;
    @(negedge clk);
    do_reset();
    // R8 reset values visible through reads
    rd(A_MODE, "R8"); rd(A_KICK, "R8"); rd(16'h1234, "R8");
    check(req_seen, 0, "R11 no request after reset");

    // R1/R5/R9: legal write, period 2^11 on tick_lo
    wr(A_MODE, 'h60, "R1");
    rd(A_MODE, "R8");
    idle(2047, 1, 0, "R9");
    check(req_seen, 0, "R9 no overflow one tick short");
    wr(A_KICK, 'hAC, "R5");
    rd(A_KICK, "R8");
    base = req_seen;
    idle(2047, 1, 0, "R5");
    check(req_seen - base, 0, "R5 restart zeroed counter");
    idle(1, 1, 0, "R9");
    check(req_seen - base, 1, "R9 overflow at 2^11");
    // restart and overflow in the same cycle: restart wins
    idle(2047, 1, 0, "R5");
    step(1, 0, 0, A_KICK, 'hAC, 1, 0, "R5");
    check(req_seen - base, 1, "R5 restart beats overflow");
    // R10 unselected source ignored
    idle(3000, 0, 1, "R10");
    check(req_seen - base, 1, "R10 tick_hi ignored");
    // R6 wrong code, R7 bit access, R1 second write
    base = req_seen;
    wr(A_KICK, 'h55, "R6");
    step(0, 1, 1, A_KICK, 0, 0, 0, "R7");
    step(1, 0, 1, A_KICK, 'hAC, 0, 0, "R7");
    wr(A_MODE, 'h61, "R1");
    rd(A_MODE, "R1");
    check(req_seen - base, 4, "R6 R7 R1 violation pulses");

    // R4 bad tag then legal write with tick_hi, period 2^12
    do_reset();
    base = req_seen;
    wr(A_MODE, 'hE1, "R4");
    rd(A_MODE, "R4");
    wr(A_MODE, 'h69, "R4");
    check(req_seen - base, 1, "R4 bad tag rejected, retry accepted");
    idle(4095, 1, 1, "R10");
    idle(200, 1, 0, "R10");
    check(req_seen - base, 1, "R10 tick_lo ignored on source 1");
    idle(1, 0, 1, "R9");
    check(req_seen - base, 2, "R9 overflow at 2^12");

    // R2 stopped watchdog
    do_reset();
    base = req_seen;
    wr(A_MODE, 'h70, "R2");
    idle(3000, 1, 1, "R2");
    wr(A_MODE, 'h60, "R2");
    rd(A_MODE, "R2");
    check(req_seen - base, 0, "R2 stopped, later writes harmless");

    // R3 single-bit mode write ignored
    do_reset();
    base = req_seen;
    step(1, 0, 1, A_MODE, 'h60, 0, 0, "R3");
    rd(A_MODE, "R3");
    wr(A_MODE, 'h60, "R3");
    rd(A_MODE, "R3");
    check(req_seen - base, 0, "R3 bit write not counted");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule